// File: doc/BRIEF.md
# Ethernet Transmit Frame Sequencer

This block turns a small ring of transmit descriptors into Ethernet frames on a MII/GMII-style output. Each descriptor owns a fixed-size byte buffer, a length, and four control flags: ready (the host hands the descriptor to the block), last (the buffer closes a frame), interrupt (pulse an event when the descriptor completes) and pad (pad a short frame to the minimum size). The block walks the ring in order. It sends a preamble and start delimiter, then the buffer bytes of one or more descriptors, then zero padding when needed, and finally the frame check sequence.

After each buffer, the block hands the descriptor back to the host by clearing its ready flag. Only the descriptor that closes the frame also receives a completion status. A graceful stop input lets the host halt the transmitter between frames without cutting a frame short. A mode input selects a 4-bit bus, with two cycles per byte, or an 8-bit bus, with one cycle per byte.

The host writes descriptors and buffer bytes through a simple write port. It reads the flags and status of any descriptor back through a combinational read port.

Top module: `eth_tx_sequencer`

## Requirements
- R1: After reset, txEn, txIrq and gtsDone are low, and every descriptor reads back as not ready with clear status.
- R2: A frame is sent as seven 0x55 bytes, one 0xD5 byte, the data bytes, then four check bytes. txEn stays high throughout and drops in the cycle right after the last check byte (or its high nibble).
- R3: The check sequence is the reflected CRC-32 (polynomial 0x04C11DB7, reflected constant 0xEDB88320, initial value all ones, final inversion) over all data and pad bytes. Bits 7:0 of the inverted remainder go out first, then bits 15:8, and so on.
- R4: If the pad flag of a frame's first descriptor is set and the frame carries fewer than 60 data bytes, zero bytes are appended up to 60 data bytes. If the pad flag is clear, or the frame already has 60 or more data bytes, no padding is added.
- R5: A descriptor whose last flag is clear is handed back with ready cleared and done status left 0. The first byte of the next descriptor in the ring follows its final byte with no gap.
- R6: The descriptor that closes a frame is written back once its last check byte has been sent: ready clear, done set, and padded set only if padding was inserted. The read-back layout is bit5 padded, bit4 done, bit3 pad, bit2 interrupt, bit1 last, bit0 ready.
- R7: txIrq pulses for one cycle for each completed descriptor whose interrupt flag is set, and never for a descriptor whose interrupt flag is clear.
- R8: The ring index advances after each descriptor and returns to 0 after index ringLast. When the current descriptor is not ready, the block waits idle until the host sets its ready flag.
- R9: While gtsReq is high and no frame is in progress, no frame starts and gtsDone pulses once. After gtsReq drops, transmission resumes with the next ready descriptor.
- R10: If gtsReq rises during a frame, that frame is finished completely. Then gtsDone pulses and no further frame starts until gtsReq drops.
- R11: With gigMode low, each byte takes two cycles on txData[3:0], low nibble first, and txData[7:4] is 0.
- R12: With gigMode high, each byte takes one cycle on txData[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| gigMode | input | 1 | 1: byte-wide output, 0: nibble-wide output |
| gtsReq | input | 1 | Graceful stop request |
| ringLast | input | IDXW | Index of the last descriptor in the ring |
| hostCtlWe | input | 1 | Write flags and length of descriptor hostIdx |
| hostDatWe | input | 1 | Write one buffer byte of descriptor hostIdx |
| hostIdx | input | IDXW | Descriptor selected for a host write |
| hostOff | input | OFFW | Byte offset for a buffer write |
| hostCtlFlags | input | 4 | {pad, interrupt, last, ready} |
| hostLen | input | LENW | Buffer length in bytes, 1 to BUF_BYTES |
| hostByte | input | 8 | Buffer byte value |
| hostRdIdx | input | IDXW | Descriptor selected for read-back |
| hostRdFlags | output | 6 | {padded, done, pad, interrupt, last, ready} |
| txEn | output | 1 | Transmit enable |
| txData | output | 8 | Transmit data (byte or low nibble) |
| txIrq | output | 1 | Descriptor-complete event pulse |
| gtsDone | output | 1 | Graceful-stop-complete pulse |

## Verification
The assertions assume the following about the inputs:
- gigMode and ringLast do not change while a frame is on the wire, and ringLast stays below the descriptor count.
- Every buffer length is between 1 and the buffer size.
- The host sets ready on the later descriptors of a frame before the first one.
- The host never rewrites a descriptor that is still marked ready.

The stimulus keeps to these rules. It changes the mode and programs the ring only while the block is idle or stopped. It writes the flags of the first descriptor of each frame last. The only descriptor it writes while a frame is running is one the block has not yet reached.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

  localparam int PREAMBLE_LEN = 7;
  localparam int MIN_DATA     = 60;
  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef enum logic [2:0] {
    SEL_IDLE, SEL_PRE, SEL_SFD, SEL_DATA, SEL_PAD, SEL_FCS
  } byteSel_t;

  typedef struct packed {
    logic     active;
    byteSel_t sel;
    logic [1:0] fcsIdx;
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SFD, ST_DATA, ST_PAD, ST_FCS, ST_STOP
  } txState_t;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/txseq_desc_table.sv
module txseq_desc_table #(
  parameter int NUM_DESC  = 4,
  parameter int BUF_BYTES = 16,
  parameter int IDXW      = 2,
  parameter int OFFW      = 4,
  parameter int LENW      = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hostCtlWe,
  input  logic            hostDatWe,
  input  logic [IDXW-1:0] hostIdx,
  input  logic [OFFW-1:0] hostOff,
  input  logic [3:0]      hostCtlFlags,
  input  logic [LENW-1:0] hostLen,
  input  logic [7:0]      hostByte,
  input  logic [IDXW-1:0] hostRdIdx,
  output logic [5:0]      hostRdFlags,
  input  logic [IDXW-1:0] curIdx,
  input  logic [OFFW-1:0] curOff,
  output logic            curRdy,
  output logic            curLast,
  output logic            curIntr,
  output logic            curPad,
  output logic [LENW-1:0] curLen,
  output logic [7:0]      curByte,
  input  logic            wbEn,
  input  logic            wbFinal,
  input  logic            wbPadded
);

  logic [7:0]      bufMem  [NUM_DESC][BUF_BYTES];
  logic [LENW-1:0] lenQ    [NUM_DESC];
  logic [NUM_DESC-1:0] rdyQ, lastQ, intrQ, padQ, doneQ, paddedQ;

  always_ff @(posedge clk) begin
    if (hostDatWe) bufMem[hostIdx][hostOff] <= hostByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdyQ <= '0; lastQ <= '0; intrQ <= '0; padQ <= '0; doneQ <= '0; paddedQ <= '0;
      for (int i = 0; i < NUM_DESC; i++) lenQ[i] <= '0;
    end else begin
      if (wbEn) begin
        rdyQ[curIdx]    <= 1'b0;
        doneQ[curIdx]   <= wbFinal;
        paddedQ[curIdx] <= wbPadded;
      end
      if (hostCtlWe) begin
        rdyQ[hostIdx]    <= hostCtlFlags[0];
        lastQ[hostIdx]   <= hostCtlFlags[1];
        intrQ[hostIdx]   <= hostCtlFlags[2];
        padQ[hostIdx]    <= hostCtlFlags[3];
        lenQ[hostIdx]    <= hostLen;
        doneQ[hostIdx]   <= 1'b0;
        paddedQ[hostIdx] <= 1'b0;
      end
    end
  end

  always_comb begin
    curRdy  = rdyQ[curIdx];
    curLast = lastQ[curIdx];
    curIntr = intrQ[curIdx];
    curPad  = padQ[curIdx];
    curLen  = lenQ[curIdx];
    curByte = bufMem[curIdx][curOff];
    hostRdFlags = {paddedQ[hostRdIdx], doneQ[hostRdIdx], padQ[hostRdIdx],
                   intrQ[hostRdIdx], lastQ[hostRdIdx], rdyQ[hostRdIdx]};
  end

  // R6: the block only hands back a descriptor it currently owns
  assert_wb_owned_R6: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> curRdy);

  // R5: a ready flag falls only by writeback or by a host write
  for (genvar g = 0; g < NUM_DESC; g++) begin : gRdyChk
    assert_rdy_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(rdyQ[g]) |-> ($past(wbEn) && $past(curIdx) == IDXW'(g)) ||
                         ($past(hostCtlWe) && $past(hostIdx) == IDXW'(g)));
  end

endmodule

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
  import txseq_pkg::*;
#(
  parameter int IDXW = 2,
  parameter int OFFW = 4,
  parameter int LENW = 5,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            gtsReq,
  input  logic [IDXW-1:0] ringLast,
  input  logic            curRdy,
  input  logic            curLast,
  input  logic            curIntr,
  input  logic            curPad,
  input  logic [LENW-1:0] curLen,
  input  logic            advance,
  output logic [IDXW-1:0] curIdx,
  output logic [OFFW-1:0] curOff,
  output dpCtl_t          dpCtl,
  output logic            wbEn,
  output logic            wbFinal,
  output logic            wbPadded,
  output logic            txIrq,
  output logic            gtsDone
);

  localparam logic [CNTW-1:0] MIN_CNT = CNTW'(MIN_DATA);

  txState_t        state;
  logic [2:0]      preCnt;
  logic [1:0]      fcsCnt;
  logic [CNTW-1:0] dataCnt;
  logic            padFlag, padUsed;
  logic            lastByteOfBuf, bufDone, fcsDone;
  logic [IDXW-1:0] nextIdx;

  always_comb begin
    lastByteOfBuf = (curOff == OFFW'(curLen - LENW'(1)));
    bufDone  = (state == ST_DATA) && advance && lastByteOfBuf;
    fcsDone  = (state == ST_FCS) && advance && (fcsCnt == 2'd3);
    wbEn     = (bufDone && !curLast) || fcsDone;
    wbFinal  = fcsDone;
    wbPadded = fcsDone && padUsed;
    nextIdx  = (curIdx == ringLast) ? '0 : curIdx + IDXW'(1);
    dpCtl.fcsIdx = fcsCnt;
    case (state)
      ST_PRE:  begin dpCtl.active = 1'b1; dpCtl.sel = SEL_PRE;  end
      ST_SFD:  begin dpCtl.active = 1'b1; dpCtl.sel = SEL_SFD;  end
      ST_DATA: begin dpCtl.active = 1'b1; dpCtl.sel = SEL_DATA; end
      ST_PAD:  begin dpCtl.active = 1'b1; dpCtl.sel = SEL_PAD;  end
      ST_FCS:  begin dpCtl.active = 1'b1; dpCtl.sel = SEL_FCS;  end
      default: begin dpCtl.active = 1'b0; dpCtl.sel = SEL_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curIdx  <= '0;
      curOff  <= '0;
      preCnt  <= '0;
      fcsCnt  <= '0;
      dataCnt <= '0;
      padFlag <= 1'b0;
      padUsed <= 1'b0;
      txIrq   <= 1'b0;
      gtsDone <= 1'b0;
    end else begin
      txIrq   <= wbEn && curIntr;
      gtsDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (gtsReq) begin
            state   <= ST_STOP;
            gtsDone <= 1'b1;
          end else if (curRdy) begin
            state   <= ST_PRE;
            preCnt  <= '0;
            fcsCnt  <= '0;
            curOff  <= '0;
            dataCnt <= '0;
            padFlag <= curPad;
            padUsed <= 1'b0;
          end
        end
        ST_PRE: if (advance) begin
          if (preCnt == 3'(PREAMBLE_LEN - 1)) state <= ST_SFD;
          else preCnt <= preCnt + 3'd1;
        end
        ST_SFD: if (advance) state <= ST_DATA;
        ST_DATA: if (advance) begin
          dataCnt <= dataCnt + CNTW'(1);
          if (lastByteOfBuf) begin
            curOff <= '0;
            if (!curLast) begin
              curIdx <= nextIdx;
            end else if (padFlag && (dataCnt + CNTW'(1) < MIN_CNT)) begin
              state   <= ST_PAD;
              padUsed <= 1'b1;
            end else begin
              state  <= ST_FCS;
              fcsCnt <= '0;
            end
          end else begin
            curOff <= curOff + OFFW'(1);
          end
        end
        ST_PAD: if (advance) begin
          dataCnt <= dataCnt + CNTW'(1);
          if (dataCnt + CNTW'(1) == MIN_CNT) begin
            state  <= ST_FCS;
            fcsCnt <= '0;
          end
        end
        ST_FCS: if (advance) begin
          if (fcsCnt == 2'd3) begin
            state  <= ST_IDLE;
            curIdx <= nextIdx;
          end else begin
            fcsCnt <= fcsCnt + 2'd1;
          end
        end
        ST_STOP: if (!gtsReq) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the enable ends only out of the check-sequence phase
  assert_en_after_fcs_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dpCtl.active) |-> $past(state) == ST_FCS);

  // R4: a padded frame never reaches its check bytes below the minimum
  assert_pad_min_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FCS && padFlag) |-> dataCnt >= MIN_CNT);

  // R9: with a stop request pending while idle, nothing starts
  assert_gts_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (gtsReq && state == ST_IDLE) |=> !dpCtl.active);

  // R7: every event pulse follows a descriptor writeback
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> $past(wbEn));

endmodule

// File: rtl/txseq_datapath.sv
module txseq_datapath
  import txseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic [7:0] dataByte,
  input  logic       gigMode,
  output logic       advance,
  output logic       txEn,
  output logic [7:0] txData
);

  logic [31:0] crcQ, fcsWord;
  logic        nibPhase;
  logic [7:0]  curByte;

  always_comb begin
    fcsWord = ~crcQ;
    case (ctl.sel)
      SEL_PRE:  curByte = PRE_BYTE;
      SEL_SFD:  curByte = SFD_BYTE;
      SEL_DATA: curByte = dataByte;
      SEL_FCS:  curByte = fcsWord[8*ctl.fcsIdx +: 8];
      default:  curByte = 8'h00;
    endcase
    advance = ctl.active && (gigMode || nibPhase);
    txEn    = ctl.active;
    if (!ctl.active)  txData = 8'h00;
    else if (gigMode) txData = curByte;
    else              txData = {4'h0, nibPhase ? curByte[7:4] : curByte[3:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nibPhase <= 1'b0;
      crcQ     <= '1;
    end else begin
      if (!ctl.active)  nibPhase <= 1'b0;
      else if (!gigMode) nibPhase <= ~nibPhase;
      if (ctl.sel == SEL_IDLE) crcQ <= '1;
      else if (advance && (ctl.sel == SEL_DATA || ctl.sel == SEL_PAD))
        crcQ <= crcStep(crcQ, curByte);
    end
  end

  // R11: in nibble mode a byte never completes in two adjacent cycles
  assert_nib_rate_R11: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !gigMode) |=> !advance);

  // R3: the remainder is frozen while its bytes are being sent
  assert_fcs_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == SEL_FCS && $past(ctl.sel == SEL_FCS)) |-> $stable(crcQ));

endmodule

// File: rtl/eth_tx_sequencer.sv
module eth_tx_sequencer
  import txseq_pkg::*;
#(
  parameter int NUM_DESC  = 4,
  parameter int BUF_BYTES = 16,
  localparam int IDXW = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int OFFW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
  localparam int LENW = $clog2(BUF_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            gigMode,
  input  logic            gtsReq,
  input  logic [IDXW-1:0] ringLast,
  input  logic            hostCtlWe,
  input  logic            hostDatWe,
  input  logic [IDXW-1:0] hostIdx,
  input  logic [OFFW-1:0] hostOff,
  input  logic [3:0]      hostCtlFlags,
  input  logic [LENW-1:0] hostLen,
  input  logic [7:0]      hostByte,
  input  logic [IDXW-1:0] hostRdIdx,
  output logic [5:0]      hostRdFlags,
  output logic            txEn,
  output logic [7:0]      txData,
  output logic            txIrq,
  output logic            gtsDone
);

  localparam int CNTW = $clog2(NUM_DESC * BUF_BYTES + MIN_DATA + 1);

  logic [IDXW-1:0] curIdx;
  logic [OFFW-1:0] curOff;
  logic            curRdy, curLast, curIntr, curPad;
  logic [LENW-1:0] curLen;
  logic [7:0]      curByte;
  logic            wbEn, wbFinal, wbPadded, advance;
  dpCtl_t          dpCtl;

  txseq_desc_table #(
    .NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES),
    .IDXW(IDXW), .OFFW(OFFW), .LENW(LENW)
  ) uTable (
    .clk(clk), .rstN(rstN),
    .hostCtlWe(hostCtlWe), .hostDatWe(hostDatWe), .hostIdx(hostIdx),
    .hostOff(hostOff), .hostCtlFlags(hostCtlFlags), .hostLen(hostLen),
    .hostByte(hostByte), .hostRdIdx(hostRdIdx), .hostRdFlags(hostRdFlags),
    .curIdx(curIdx), .curOff(curOff), .curRdy(curRdy), .curLast(curLast),
    .curIntr(curIntr), .curPad(curPad), .curLen(curLen), .curByte(curByte),
    .wbEn(wbEn), .wbFinal(wbFinal), .wbPadded(wbPadded)
  );

  txseq_ctrl #(
    .IDXW(IDXW), .OFFW(OFFW), .LENW(LENW), .CNTW(CNTW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .gtsReq(gtsReq), .ringLast(ringLast),
    .curRdy(curRdy), .curLast(curLast), .curIntr(curIntr), .curPad(curPad),
    .curLen(curLen), .advance(advance), .curIdx(curIdx), .curOff(curOff),
    .dpCtl(dpCtl), .wbEn(wbEn), .wbFinal(wbFinal), .wbPadded(wbPadded),
    .txIrq(txIrq), .gtsDone(gtsDone)
  );

  txseq_datapath uDatapath (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .dataByte(curByte),
    .gigMode(gigMode), .advance(advance), .txEn(txEn), .txData(txData)
  );

endmodule

// File: tb/tb_eth_tx_sequencer.sv
module tb_eth_tx_sequencer;

  localparam int ND = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       gigMode = 1'b1;
  logic       gtsReq = 1'b0;
  logic [1:0] ringLast = 2'd3;
  logic       hostCtlWe = 1'b0, hostDatWe = 1'b0;
  logic [1:0] hostIdx = '0;
  logic [3:0] hostOff = '0;
  logic [3:0] hostCtlFlags = '0;
  logic [4:0] hostLen = '0;
  logic [7:0] hostByte = '0;
  logic [1:0] hostRdIdx = '0;
  logic [5:0] hostRdFlags;
  logic       txEn, txIrq, gtsDone;
  logic [7:0] txData;

  eth_tx_sequencer #(.NUM_DESC(ND), .BUF_BYTES(16)) dut (
    .clk(clk), .rstN(rstN), .gigMode(gigMode), .gtsReq(gtsReq), .ringLast(ringLast),
    .hostCtlWe(hostCtlWe), .hostDatWe(hostDatWe), .hostIdx(hostIdx), .hostOff(hostOff),
    .hostCtlFlags(hostCtlFlags), .hostLen(hostLen), .hostByte(hostByte),
    .hostRdIdx(hostRdIdx), .hostRdFlags(hostRdFlags), .txEn(txEn), .txData(txData),
    .txIrq(txIrq), .gtsDone(gtsDone)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic       gig;
    logic [2:0] nBufs;
    logic [4:0] lenA;
    logic [4:0] lenLast;
    logic       pad;
    logic [3:0] irqMask;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd1, 5'd0,  5'd10, 1'b1, 4'b0001},
    '{1'b0, 3'd1, 5'd0,  5'd10, 1'b1, 4'b0001},
    '{1'b1, 3'd3, 5'd8,  5'd8,  1'b0, 4'b0100},
    '{1'b1, 3'd4, 5'd16, 5'd12, 1'b1, 4'b1010},
    '{1'b0, 3'd2, 5'd5,  5'd3,  1'b1, 4'b0011},
    '{1'b1, 3'd4, 5'd16, 5'd16, 1'b1, 4'b0000},
    '{1'b1, 3'd2, 5'd1,  5'd1,  1'b0, 4'b0011},
    '{1'b0, 3'd3, 5'd16, 5'd16, 1'b1, 4'b0111}
  };

  int nChecks = 0, nFail = 0;
  int ringPos = 0;
  int frameCount = 0, irqCount = 0, gtsCount = 0, enCycles = 0;
  bit prevEn = 0, half = 0, nibHiBad = 0;
  logic [3:0] lowNib;
  logic [7:0] capQ [$];

  always @(negedge clk) begin
    if (txEn) begin
      enCycles++;
      if (gigMode) capQ.push_back(txData);
      else begin
        if (txData[7:4] != 4'h0) nibHiBad = 1;
        if (!half) begin lowNib = txData[3:0]; half = 1; end
        else begin capQ.push_back({txData[3:0], lowNib}); half = 0; end
      end
    end else begin
      half = 0;
      if (prevEn) frameCount++;
    end
    prevEn = txEn;
    if (txIrq) irqCount++;
    if (gtsDone) gtsCount++;
  end

  task automatic chk(input bit ok, input string msg);
    nChecks++;
    if (!ok) begin nFail++; $display("FAIL %s", msg); end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  function automatic logic [7:0] dv(int seed, int k, int o);
    return 8'(seed * 29 + k * 17 + o * 5 + 3);
  endfunction

  function automatic logic [31:0] refCrc(logic [7:0] q [$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (q[i]) begin
      c = c ^ {24'h0, q[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic writeCtl(int idx, logic [3:0] fl, int len);
    @(negedge clk);
    hostCtlWe = 1; hostIdx = 2'(idx); hostCtlFlags = fl; hostLen = 5'(len);
    @(negedge clk);
    hostCtlWe = 0;
  endtask

  task automatic writeByte(int idx, int off, logic [7:0] b);
    @(negedge clk);
    hostDatWe = 1; hostIdx = 2'(idx); hostOff = 4'(off); hostByte = b;
    @(negedge clk);
    hostDatWe = 0;
  endtask

  task automatic progFrame(logic gig, int n, int lenA, int lenLast, logic pad,
                           logic [3:0] mask, int seed, bit arm, output int startIdx);
    startIdx = ringPos;
    gigMode = gig;
    for (int k = 0; k < n; k++) begin
      int len = (k == n - 1) ? lenLast : lenA;
      for (int o = 0; o < len; o++) writeByte((ringPos + k) % ND, o, dv(seed, k, o));
    end
    for (int k = n - 1; k >= 0; k--) begin
      int len = (k == n - 1) ? lenLast : lenA;
      bit rdy = (k == 0) ? arm : 1'b1;
      writeCtl((ringPos + k) % ND, {pad, mask[k], k == n - 1, rdy}, len);
    end
    ringPos = (ringPos + n) % ND;
  endtask

  task automatic waitFrame(int target, string tag);
    int t = 0;
    while (frameCount < target && t < 4000) begin @(negedge clk); t++; end
    chk(frameCount >= target, $sformatf("%s frame end: actual count %0d expected %0d", tag, frameCount, target));
    repeat (3) @(negedge clk);
  endtask

  task automatic verifyFrame(logic gig, int n, int lenA, int lenLast, logic pad,
                             logic [3:0] mask, int seed, int startIdx, int irqBase, string tag);
    logic [7:0] dataQ [$];
    logic [7:0] expQ [$];
    logic [31:0] fcs;
    int total, nIrq, bad;
    bit padded;
    for (int k = 0; k < n; k++) begin
      int len = (k == n - 1) ? lenLast : lenA;
      for (int o = 0; o < len; o++) dataQ.push_back(dv(seed, k, o));
    end
    total = dataQ.size();
    padded = pad && total < 60;
    if (padded) while (dataQ.size() < 60) dataQ.push_back(8'h00);
    fcs = refCrc(dataQ);
    for (int i = 0; i < 7; i++) expQ.push_back(8'h55);
    expQ.push_back(8'hD5);
    foreach (dataQ[i]) expQ.push_back(dataQ[i]);
    for (int i = 0; i < 4; i++) expQ.push_back(fcs[8*i +: 8]);
    chk(capQ.size() == expQ.size(), $sformatf("%s R2 R4 length: actual %0d expected %0d",
        tag, capQ.size(), expQ.size()));
    bad = -1;
    for (int i = 0; i < expQ.size() && i < capQ.size(); i++)
      if (bad < 0 && capQ[i] !== expQ[i]) bad = i;
    if (bad >= 0)
      chk(0, $sformatf("%s R2 R3 %s byte %0d: actual %h expected %h", tag,
          gig ? "R12" : "R11", bad, capQ[bad], expQ[bad]));
    else chk(1, "");
    if (!gig) chk(!nibHiBad, $sformatf("%s R11 upper nibble: actual nonzero expected 0", tag));
    nIrq = 0;
    for (int k = 0; k < n; k++) if (mask[k]) nIrq++;
    chk(irqCount - irqBase == nIrq, $sformatf("%s R7 irq pulses: actual %0d expected %0d",
        tag, irqCount - irqBase, nIrq));
    for (int k = 0; k < n; k++) begin
      logic [5:0] expF;
      bit fin = (k == n - 1);
      expF = {fin && padded, fin, pad, mask[k], fin, 1'b0};
      @(negedge clk);
      hostRdIdx = 2'((startIdx + k) % ND);
      #1;
      chk(hostRdFlags === expF, $sformatf("%s %s desc %0d flags: actual %b expected %b",
          tag, fin ? "R6" : "R5", (startIdx + k) % ND, hostRdFlags, expF));
    end
  endtask

  initial begin
    int s0, s1, fc, ib, enSnap;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(!txEn && !txIrq && !gtsDone, $sformatf("R1 outputs: actual %b%b%b expected 000", txEn, txIrq, gtsDone));
    for (int i = 0; i < ND; i++) begin
      hostRdIdx = 2'(i); #1;
      chk(hostRdFlags == 6'b0, $sformatf("R1 desc %0d: actual %b expected 000000", i, hostRdFlags));
    end

    // Vector table; the ring wraps several times (R8)
    for (int v = 0; v < NVEC; v++) begin
      vec_t x = VECS[v];
      capQ.delete(); nibHiBad = 0;
      fc = frameCount; ib = irqCount;
      progFrame(x.gig, int'(x.nBufs), int'(x.lenA), int'(x.lenLast), x.pad, x.irqMask, v, 1'b1, s0);
      waitFrame(fc + 1, $sformatf("vec%0d R8", v));
      verifyFrame(x.gig, int'(x.nBufs), int'(x.lenA), int'(x.lenLast), x.pad, x.irqMask, v, s0, ib,
                  $sformatf("vec%0d", v));
    end

    // R8: not-ready descriptor holds the block idle
    capQ.delete(); nibHiBad = 0; fc = frameCount; ib = irqCount;
    progFrame(1'b1, 1, 0, 7, 1'b0, 4'b0001, 20, 1'b0, s0);
    enSnap = enCycles;
    repeat (40) @(negedge clk);
    chk(enCycles == enSnap, $sformatf("R8 idle on not-ready: actual %0d tx cycles expected 0", enCycles - enSnap));
    writeCtl(s0, {1'b0, 1'b1, 1'b1, 1'b1}, 7);
    waitFrame(fc + 1, "R8 release");
    verifyFrame(1'b1, 1, 0, 7, 1'b0, 4'b0001, 20, s0, ib, "R8 release");

    // R9: stop while idle
    gtsCount = 0;
    @(negedge clk); gtsReq = 1;
    repeat (5) @(negedge clk);
    chk(gtsCount == 1, $sformatf("R9 stop event: actual %0d expected 1", gtsCount));
    capQ.delete(); nibHiBad = 0; fc = frameCount; ib = irqCount;
    progFrame(1'b0, 2, 4, 6, 1'b1, 4'b0010, 21, 1'b1, s0);
    enSnap = enCycles;
    repeat (50) @(negedge clk);
    chk(enCycles == enSnap, $sformatf("R9 no start while stopped: actual %0d tx cycles expected 0", enCycles - enSnap));
    gtsReq = 0;
    waitFrame(fc + 1, "R9 resume");
    verifyFrame(1'b0, 2, 4, 6, 1'b1, 4'b0010, 21, s0, ib, "R9 resume");

    // R10: stop requested during a frame
    gtsCount = 0;
    capQ.delete(); nibHiBad = 0; fc = frameCount; ib = irqCount;
    progFrame(1'b1, 2, 16, 4, 1'b0, 4'b0011, 22, 1'b1, s0);
    begin
      int t = 0;
      while (!txEn && t < 200) begin @(negedge clk); t++; end
    end
    gtsReq = 1;
    progFrame(1'b1, 1, 0, 6, 1'b1, 4'b0001, 23, 1'b1, s1);
    waitFrame(fc + 1, "R10 current");
    verifyFrame(1'b1, 2, 16, 4, 1'b0, 4'b0011, 22, s0, ib, "R10 current");
    chk(gtsCount == 1, $sformatf("R10 stop event after frame: actual %0d expected 1", gtsCount));
    capQ.delete(); ib = irqCount; enSnap = enCycles;
    repeat (40) @(negedge clk);
    chk(enCycles == enSnap && frameCount == fc + 1,
        $sformatf("R10 held after stop: actual %0d tx cycles expected 0", enCycles - enSnap));
    gtsReq = 0;
    waitFrame(fc + 2, "R10 resume");
    verifyFrame(1'b1, 1, 0, 6, 1'b1, 4'b0001, 23, s1, ib, "R10 resume");

    finishRun();
  end

endmodule